// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does this by fetching one 4-byte translation entry from a flat, single-level table in memory. A requester presents the address, the kind of access (read, write or execute), the table base of the running program and that program's table limit. The walker first checks the virtual page number against the limit. It then reads the entry at base plus page number times four and checks the entry's valid and permission bits. It answers with either a physical address or a fault code.

The walker keeps the usage bits of each mapping current in hardware. When a permitted access finds the reference bit clear, it writes the entry back with that bit set. The same happens when a write finds the dirty bit clear, in which case both bits are set. An entry that needs no change costs a single memory read. Only one walk is in flight at a time. The base and limit are captured when a request is accepted, so software can reload them between requests to switch to another program's table.

Top module: `ptw_walker`

## Requirements
- R1: For each request within its limit, the walker issues exactly one memory read (`mem_we`=0). The read address is the captured base plus the 20-bit virtual page number (address bits 31..12) shifted left by 2.
- R2: When the virtual page number is greater than the limit, the response carries fault code 1 and a zero address, and no memory access is made. A page number equal to the limit is allowed.
- R3: When entry bit 4 (valid) is clear, the response carries fault code 2 and a zero address, and no write-back is made.
- R4: Access type 0 (read) needs entry bit 0. Type 1 (write) needs bit 1. Type 2 (execute) needs bit 5. Type 3 is never permitted. A valid entry without the needed bit gives fault code 3, a zero address and no write-back.
- R5: A permitted access responds with fault code 0. The physical address is entry bits 31..12 followed by virtual address bits 11..0.
- R6: A permitted access to an entry with bit 2 (reference) clear is followed by one memory write to the same entry address. The written entry equals the read entry with bit 2 set, plus bit 3 when the access is a write.
- R7: A permitted write access to an entry with bit 3 (dirty) clear writes the entry back with bits 2 and 3 both set.
- R8: When the permitted access would change neither bit 2 nor bit 3, no memory write is made.
- R9: `req_ready` is low from the cycle after acceptance until the response has been given. Each accepted request produces exactly one single-cycle `rsp_valid` pulse.
- R10: The base and limit used by a walk are the values presented at acceptance. Changing those inputs during a walk has no effect, while a new value given with the next request does take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted when both high |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| req_base | input | 32 | Table base of the current program |
| req_limit | input | 20 | Highest permitted virtual page number |
| mem_req | output | 1 | One-cycle memory command |
| mem_we | output | 1 | Command is a write (1) or read (0) |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for a write-back |
| mem_ack | input | 1 | One-cycle completion of the outstanding command |
| mem_rdata | input | 32 | Read entry, valid with `mem_ack` of a read |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Physical address, zero on any fault |
| rsp_fault | output | 2 | 0 none, 1 limit, 2 not mapped, 3 protection |

## Verification
The assertions assume that the memory answers each command with exactly one `mem_ack` pulse, and never acknowledges while no command is outstanding. They also assume `mem_rdata` is stable during the acknowledge cycle of a read. The bench memory model meets these rules: it returns every command's acknowledge a fixed two cycles later, and the walker only ever has one command open. Requests are raised only while `req_ready` is high. Every combination of the six entry flag bits is swept against all four access types, under two bases with different limits.

// File: rtl/ptw_pkg.sv
// Package ptw_pkg
// Holds the access and fault encodings and the bit positions inside a
// translation entry. All walker modules share it.
// Assumes a 32-bit entry with the physical page number in its top bits.
package ptw_pkg;

    localparam int PTE_W     = 32;

    localparam int BIT_RD    = 0;
    localparam int BIT_WR    = 1;
    localparam int BIT_REF   = 2;
    localparam int BIT_DIRTY = 3;
    localparam int BIT_VALID = 4;
    localparam int BIT_EX    = 5;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_LIMIT = 2'd1,
        FLT_PAGE  = 2'd2,
        FLT_PROT  = 2'd3
    } flt_e;

endpackage

// File: rtl/ptw_addr_gen.sv
// Module ptw_addr_gen
// Purely combinational. Forms the byte address of a translation entry and
// flags a page number that lies above the limit.
// Assumes entries of 2**PTE_LOG2 bytes and a table base of VA_W bits.
module ptw_addr_gen #(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PTE_LOG2  = 2,
    localparam int VPN_W    = VA_W - PAGE_BITS
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [VA_W-1:0]  base,
    input  logic [VPN_W-1:0] limit,
    output logic [VA_W-1:0]  pte_addr,
    output logic             over_limit
);

    logic [VPN_W-1:0] vpn;

    // Split the page number off and scale it by the entry size.
    always_comb begin
        vpn        = vaddr[VA_W-1:PAGE_BITS];
        pte_addr   = base + (VA_W'(vpn) << PTE_LOG2);
        over_limit = (vpn > limit);
    end

endmodule

// File: rtl/ptw_pte_check.sv
// Module ptw_pte_check
// Purely combinational. Decides whether an entry allows the requested
// access, and builds the entry with its usage bits brought up to date.
// Assumes the bit positions from ptw_pkg. The caller skips the write-back
// whenever a fault is reported.
module ptw_pte_check
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] entry,
    input  logic [1:0]       acc,
    output logic [1:0]       fault,
    output logic [PTE_W-1:0] upd,
    output logic             wb_need
);

    logic allowed;

    // Choose the permission bit that matches the access type.
    always_comb begin
        case (acc_e'(acc))
            ACC_READ:  allowed = entry[BIT_RD];
            ACC_WRITE: allowed = entry[BIT_WR];
            ACC_EXEC:  allowed = entry[BIT_EX];
            default:   allowed = 1'b0;
        endcase
    end

    // Rank faults and build the refreshed entry.
    always_comb begin
        if (!entry[BIT_VALID])  fault = FLT_PAGE;
        else if (!allowed)      fault = FLT_PROT;
        else                    fault = FLT_NONE;
        upd          = entry;
        upd[BIT_REF] = 1'b1;
        if (acc_e'(acc) == ACC_WRITE) upd[BIT_DIRTY] = 1'b1;
        wb_need = (fault == FLT_NONE) && (upd != entry);
    end

endmodule

// File: rtl/ptw_walker.sv
// Module ptw_walker (top)
// Walks a single-level table: limit check, one entry read, permission
// check, and an optional write-back of the reference and dirty bits.
// Assumes a memory that answers every one-cycle mem_req with exactly one
// mem_ack pulse. Only one walk is open at a time.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PTE_LOG2  = 2,
    localparam int VPN_W    = VA_W - PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic [VA_W-1:0]  req_base,
    input  logic [VPN_W-1:0] req_limit,
    output logic             mem_req,
    output logic             mem_we,
    output logic [VA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_ack,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic             rsp_valid,
    output logic [PTE_W-1:0] rsp_paddr,
    output logic [1:0]       rsp_fault
);

    typedef enum logic [2:0] {
        S_IDLE, S_RD, S_RWAIT, S_WR, S_WWAIT, S_RESP
    } st_e;

    st_e                  state;
    logic [VA_W-1:0]      pte_addr_w;
    logic                 over_limit_w;
    logic [1:0]           chk_fault;
    logic [PTE_W-1:0]     chk_upd;
    logic                 chk_wb;
    logic [VA_W-1:0]      pte_addr_q;
    logic [PAGE_BITS-1:0] off_q;
    logic [1:0]           acc_q;
    logic [PTE_W-1:0]     upd_q;
    logic [PTE_W-1:0]     paddr_q;
    logic [1:0]           fault_q;

    ptw_addr_gen #(
        .VA_W      (VA_W),
        .PAGE_BITS (PAGE_BITS),
        .PTE_LOG2  (PTE_LOG2)
    ) i_addr (
        .vaddr      (req_vaddr),
        .base       (req_base),
        .limit      (req_limit),
        .pte_addr   (pte_addr_w),
        .over_limit (over_limit_w)
    );

    ptw_pte_check i_chk (
        .entry   (mem_rdata),
        .acc     (acc_q),
        .fault   (chk_fault),
        .upd     (chk_upd),
        .wb_need (chk_wb)
    );

    // Sequence the walk and hold the captured request and the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            pte_addr_q <= '0;
            off_q      <= '0;
            acc_q      <= '0;
            upd_q      <= '0;
            paddr_q    <= '0;
            fault_q    <= '0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    pte_addr_q <= pte_addr_w;
                    off_q      <= req_vaddr[PAGE_BITS-1:0];
                    acc_q      <= req_acc;
                    if (over_limit_w) begin
                        fault_q <= FLT_LIMIT;
                        paddr_q <= '0;
                        state   <= S_RESP;
                    end else begin
                        state   <= S_RD;
                    end
                end
                S_RD:    state <= S_RWAIT;
                S_RWAIT: if (mem_ack) begin
                    fault_q <= chk_fault;
                    upd_q   <= chk_upd;
                    paddr_q <= (chk_fault == FLT_NONE)
                             ? {mem_rdata[PTE_W-1:PAGE_BITS], off_q} : '0;
                    state   <= chk_wb ? S_WR : S_RESP;
                end
                S_WR:    state <= S_WWAIT;
                S_WWAIT: if (mem_ack) state <= S_RESP;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Drive the handshake, memory and response ports from the state.
    always_comb begin
        req_ready = (state == S_IDLE);
        mem_req   = (state == S_RD) || (state == S_WR);
        mem_we    = (state == S_WR);
        mem_addr  = pte_addr_q;
        mem_wdata = upd_q;
        rsp_valid = (state == S_RESP);
        rsp_paddr = paddr_q;
        rsp_fault = fault_q;
    end

    // R9
    one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[BIT_REF] && mem_wdata[BIT_VALID]);

    // R2
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault != FLT_NONE) |-> rsp_paddr == '0);

    // R1
    mem_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready && !rsp_valid);

endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [31:0] req_base = '0;
    logic [19:0] req_limit = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ptw_walker i_ptw_walker (
        .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .req_acc,
        .req_base, .req_limit, .mem_req, .mem_we, .mem_addr, .mem_wdata,
        .mem_ack, .mem_rdata, .rsp_valid, .rsp_paddr, .rsp_fault
    );

    // Memory model: two-cycle acknowledge, with command logging.
    logic [31:0] tbl [256];
    logic        ack1 = 1'b0;
    logic [31:0] rd1 = '0;
    int          rd_cnt = 0, wr_cnt = 0;
    logic [31:0] last_ra = '0, last_wa = '0, last_wd = '0;
    logic        poke_en = 1'b0;
    logic [31:0] poke_addr = '0, poke_data = '0;

    always @(posedge clk) begin
        ack1      <= mem_req;
        mem_ack   <= ack1;
        mem_rdata <= rd1;
        if (poke_en) tbl[poke_addr[9:2]] <= poke_data;
        if (mem_req) begin
            if (mem_we) begin
                tbl[mem_addr[9:2]] <= mem_wdata;
                wr_cnt  <= wr_cnt + 1;
                last_wa <= mem_addr;
                last_wd <= mem_wdata;
            end else begin
                rd1     <= tbl[mem_addr[9:2]];
                rd_cnt  <= rd_cnt + 1;
                last_ra <= mem_addr;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic walk(input logic [31:0] va, input logic [1:0] acc,
                        input logic [31:0] base, input logic [19:0] lim,
                        output logic [1:0] f, output logic [31:0] pa);
        int guard;
        @(negedge clk);
        req_vaddr = va; req_acc = acc; req_base = base; req_limit = lim;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_base  = 32'hFFFF_F000;   // R10: garbage after acceptance
        req_limit = 20'd0;
        check("R9 ready low after accept", {31'd0, req_ready}, 32'd0);
        guard = 0;
        while (!rsp_valid && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        f  = rsp_fault;
        pa = rsp_paddr;
        if (guard >= 100) check("R9 response arrives", 32'd0, 32'd1);
        @(negedge clk);
        check("R9 single pulse and ready", {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [1:0]  f;
        logic [31:0] pa;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset state", {29'd0, req_ready, rsp_valid, mem_req}, 32'd4);

        for (int bs = 0; bs < 2; bs++) begin
            for (int fl = 0; fl < 64; fl++) begin
                for (int ac = 0; ac < 4; ac++) begin
                    logic [31:0] base, pte, entry, va, exp_pa, exp_wd;
                    logic [19:0] lim, vpn, ppn;
                    logic [11:0] off;
                    logic [1:0]  exp_f;
                    logic        perm, exp_wb;
                    int          rd0, wr0;
                    base  = (bs == 0) ? 32'h0 : 32'h200;
                    lim   = (bs == 0) ? 20'd11 : 20'd7;
                    vpn   = 20'((fl + ac * 5) % 16);
                    ppn   = 20'(32'h5A000 + vpn * 37 + bs * 1000);
                    off   = 12'((fl * 61 + ac * 13) % 4096);
                    va    = {vpn, off};
                    pte   = base + {vpn, 2'b00};
                    entry = {ppn, 6'd0, 6'(fl)};
                    poke(pte, entry);
                    case (ac)
                        0: perm = entry[0];
                        1: perm = entry[1];
                        2: perm = entry[5];
                        default: perm = 1'b0;
                    endcase
                    if (vpn > lim)       exp_f = 2'd1;
                    else if (!entry[4])  exp_f = 2'd2;
                    else if (!perm)      exp_f = 2'd3;
                    else                 exp_f = 2'd0;
                    exp_pa = (exp_f == 2'd0) ? {ppn, off} : 32'd0;
                    exp_wd = entry | 32'd4 | ((ac == 1) ? 32'd8 : 32'd0);
                    exp_wb = (exp_f == 2'd0) && (exp_wd != entry);
                    rd0 = rd_cnt; wr0 = wr_cnt;
                    walk(va, 2'(ac), base, lim, f, pa);
                    // R2 R3 R4 R5 fault code, R10 captured base/limit
                    check("R2/R3/R4 fault code R10", {30'd0, f}, {30'd0, exp_f});
                    check("R5 physical address", pa, exp_pa);
                    if (exp_f == 2'd1) begin
                        check("R2 no memory access",
                              32'(rd_cnt - rd0 + wr_cnt - wr0), 32'd0);
                    end else begin
                        check("R1 one read", 32'(rd_cnt - rd0), 32'd1);
                        check("R1 read address", last_ra, pte);
                        if (exp_wb) begin
                            check("R6 R7 one write-back", 32'(wr_cnt - wr0), 32'd1);
                            check("R6 write-back address", last_wa, pte);
                            check("R7 written entry", last_wd, exp_wd);
                        end else begin
                            check("R8 no write-back", 32'(wr_cnt - wr0), 32'd0);
                        end
                    end
                end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule